// File: doc/BRIEF.md
# Floating-Point Mode Register Access Gate

This combinational block decides what happens when software tries to read or write the floating-point mode register. It sees the current privilege level (0 to 3), whether the top level and the hypervisor level exist or are enabled, the host-mode and routing bits, and the enable and trap bits held at each level. From these it returns exactly one verdict: the access is allowed, it is an undefined instruction, or it traps. A trap also gives the level it goes to and a 6-bit class code. Reads and writes are judged by the same rules.

The verdict comes from an ordered list of checks, and the first check that matches decides the result. The list is split into three parts. First comes the feature check, together with the debug undefined-priority check. Next come the mode-enable checks, which report class 0x18. Last come the FP-access checks, which report class 0x07, or 0x00 when a level-0 access is rerouted. Host mode and the routing bit change the target level and, in one case, the class code.

Top module: `fpmode_access_gate`

## Requirements
- R1: When `feat_present` is 0, the result is undefined at every level, whatever the other inputs are.
- R2: At levels 0 to 2, with `top_present` and `dbg_undef_prio` both 1, an access is undefined if `mon_fpm_en` is 0 or `mon_fp_trap` is 1. This check comes before every trap check.
- R3: At level 0 outside level-0 host mode (level-0 host mode is `hyp_enabled & hyp_host_e2h & hyp_route_tge`), `kern_fpm_en`=0 traps with class 0x18. The target is level 1, or level 2 when `hyp_enabled & hyp_route_tge` is 1.
- R4: At level 0 in level-0 host mode, `hyp_fpm_en`=0 traps to level 2 with class 0x18.
- R5: At levels 0 and 1, with `hyp_enabled`=1 and outside level-0 host mode, an access traps to level 2 with class 0x18 if `hx_fpm_en`=0, or if `top_present`=1 and `mon_hx_en`=0.
- R6: At levels 0 to 2, with `top_present`=1 and `mon_fpm_en`=0, an access traps to level 3 with class 0x18, or is undefined when `dbg_undef`=1. When `top_present`=0, this check and R2 do not apply.
- R7: Every mode-enable check (class 0x18) comes before every FP-access check (classes 0x07 and 0x00).
- R8: At level 0 outside host mode, `kern_fp_en`≠2'b11 traps to level 1 with class 0x07. When routing is set, it traps to level 2 with class 0x00 instead. In level-0 host mode, `hyp_fp_en`≠2'b11 traps to level 2 with class 0x07.
- R9: At level 1, `kern_fp_en[0]`=0 traps to level 1 with class 0x07.
- R10: Level-2 host mode is `hyp_enabled & hyp_host_e2h`. In that mode, `hyp_fp_en[0]`=0 traps to level 2 with class 0x07. Outside it, `hyp_fp_trap`=1 traps to level 2 with class 0x07. This needs `hyp_enabled`=1 at levels 0 and 1.
- R11: At levels 0 to 2, `top_present & mon_fp_trap` traps to level 3 with class 0x07, or is undefined when `dbg_undef`=1. At level 3, with the feature present, `mon_fp_trap`=1 is the only condition that blocks an access: it traps to level 3 with class 0x07, and every other control is ignored.
- R12: Exactly one of `acc_allow`, `acc_undef` and `acc_trap` is 1. On a trap, `trap_lvl` is at least 1 and at least `cur_lvl`. Without a trap, `trap_lvl` and `trap_class` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| feat_present | input | 1 | The mode register feature is implemented |
| cur_lvl | input | 2 | Current privilege level, binary 0 to 3 |
| top_present | input | 1 | Level 3 is implemented |
| hyp_enabled | input | 1 | Level 2 is enabled |
| hyp_host_e2h | input | 1 | Level-2 host bit |
| hyp_route_tge | input | 1 | Bit that routes level-0 exceptions to level 2 |
| mon_fpm_en | input | 1 | Level-3 mode-register enable |
| mon_hx_en | input | 1 | Level-3 enable for the hypervisor extension controls |
| mon_fp_trap | input | 1 | Level-3 FP trap bit |
| dbg_undef_prio | input | 1 | Debug condition that gives undefined checks priority |
| dbg_undef | input | 1 | Debug condition that turns level-3 traps into undefined |
| kern_fpm_en | input | 1 | Level-1 mode-register enable for level 0 |
| hyp_fpm_en | input | 1 | Level-2 mode-register enable for level 0 in host mode |
| hx_fpm_en | input | 1 | Level-2 extended-control mode-register enable |
| kern_fp_en | input | 2 | Level-1 FP access enable field |
| hyp_fp_en | input | 2 | Level-2 FP access enable field (host mode) |
| hyp_fp_trap | input | 1 | Level-2 FP trap bit (non-host) |
| acc_allow | output | 1 | The access goes ahead |
| acc_undef | output | 1 | The access is an undefined instruction |
| acc_trap | output | 1 | The access traps |
| trap_lvl | output | 2 | Target level of the trap |
| trap_class | output | 6 | Class code of the trap |

## Verification
The assertions watch the verdict continuously. They check that exactly one outcome is raised, that trap outputs are zero when no trap is taken, that a trap never goes to a lower level than the current one or to level 0, that a missing feature always gives undefined, that level 3 never gives undefined, and that the rerouted class 0x00 appears only at level 0 with target level 2. The assertions cannot show the order of the checks or which level and class each condition picks. The bench shows these: the vector table and an independent reference model, run against many biased random inputs, exercise the checks that overlap, for example a mode-enable fault together with an FP-access fault, and confirm that host mode and the routing bit change the target level and class as R3 to R11 state.

// File: rtl/fpmode_gate_pkg.sv
package fpmode_gate_pkg;

  localparam int LVL_W = 2;
  localparam int CLS_W = 6;
  localparam int FLD_W = 2;

  localparam logic [LVL_W-1:0] LV0 = 2'd0;
  localparam logic [LVL_W-1:0] LV1 = 2'd1;
  localparam logic [LVL_W-1:0] LV2 = 2'd2;
  localparam logic [LVL_W-1:0] LV3 = 2'd3;

  localparam logic [CLS_W-1:0] CLS_MODE   = 6'h18;
  localparam logic [CLS_W-1:0] CLS_FPACC  = 6'h07;
  localparam logic [CLS_W-1:0] CLS_ROUTED = 6'h00;

  typedef struct packed {
    logic             hit;
    logic             undef;
    logic [LVL_W-1:0] lvl;
    logic [CLS_W-1:0] cls;
  } verdict_t;

  typedef struct packed {
    logic top_present;
    logic hyp_enabled;
    logic host_l0;
    logic route;
    logic mon_fpm_en;
    logic mon_hx_en;
    logic dbg_undef;
    logic kern_fpm_en;
    logic hyp_fpm_en;
    logic hx_fpm_en;
  } mode_ctrl_t;

  typedef struct packed {
    logic             top_present;
    logic             hyp_enabled;
    logic             host_l0;
    logic             host_l2;
    logic             route;
    logic             mon_fp_trap;
    logic             dbg_undef;
    logic [FLD_W-1:0] kern_fp_en;
    logic [FLD_W-1:0] hyp_fp_en;
    logic             hyp_fp_trap;
  } acc_ctrl_t;

  function automatic verdict_t v_none();
    return '{hit: 1'b0, undef: 1'b0, lvl: LV0, cls: '0};
  endfunction

  function automatic verdict_t v_undef();
    return '{hit: 1'b1, undef: 1'b1, lvl: LV0, cls: '0};
  endfunction

  function automatic verdict_t v_trap(input logic [LVL_W-1:0] l,
                                      input logic [CLS_W-1:0] k);
    return '{hit: 1'b1, undef: 1'b0, lvl: l, cls: k};
  endfunction

  // Level-3 trap unless the secure-debug condition makes it undefined.
  function automatic verdict_t v_mon(input logic dbg, input logic [CLS_W-1:0] k);
    return dbg ? v_undef() : v_trap(LV3, k);
  endfunction

  function automatic logic fld_open(input logic [FLD_W-1:0] f);
    return f == '1;
  endfunction

  function automatic logic fld_low_clear(input logic [FLD_W-1:0] f);
    return !f[0];
  endfunction

endpackage

// File: rtl/fpmode_enable_rules.sv
module fpmode_enable_rules
  import fpmode_gate_pkg::*;
(
  input  logic [LVL_W-1:0] lvl,
  input  mode_ctrl_t       c,
  output verdict_t         v
);
  localparam int NSLOT = 4;

  verdict_t slot [NSLOT];

  logic r_kern, r_hostl0, r_hx, r_mon;
  assign r_kern   = !c.host_l0 && !c.kern_fpm_en;
  assign r_hostl0 = c.host_l0 && !c.hyp_fpm_en;
  assign r_hx     = c.hyp_enabled && !c.host_l0 &&
                    ((c.top_present && !c.mon_hx_en) || !c.hx_fpm_en);
  assign r_mon    = c.top_present && !c.mon_fpm_en;

  always_comb begin
    for (int i = 0; i < NSLOT; i++) slot[i] = v_none();
    unique case (lvl)
      LV0: begin
        if (r_kern)   slot[0] = v_trap(c.route ? LV2 : LV1, CLS_MODE);
        if (r_hostl0) slot[1] = v_trap(LV2, CLS_MODE);
        if (r_hx)     slot[2] = v_trap(LV2, CLS_MODE);
        if (r_mon)    slot[3] = v_mon(c.dbg_undef, CLS_MODE);
      end
      LV1: begin
        if (r_hx)     slot[0] = v_trap(LV2, CLS_MODE);
        if (r_mon)    slot[1] = v_mon(c.dbg_undef, CLS_MODE);
      end
      LV2: begin
        if (r_mon)    slot[0] = v_mon(c.dbg_undef, CLS_MODE);
      end
      default: ;
    endcase
  end

  // First matching slot wins.
  always_comb begin
    v = v_none();
    for (int i = NSLOT - 1; i >= 0; i--)
      if (slot[i].hit) v = slot[i];
  end

  always_comb begin
    // R6
    mode_cls_chk: assert (!(v.hit && !v.undef) || v.cls == CLS_MODE)
      else $error("mode-enable trap with wrong class");
  end

endmodule

// File: rtl/fpmode_access_rules.sv
module fpmode_access_rules
  import fpmode_gate_pkg::*;
(
  input  logic [LVL_W-1:0] lvl,
  input  acc_ctrl_t        c,
  output verdict_t         v
);
  localparam int NSLOT = 5;

  verdict_t slot [NSLOT];

  logic r_kern0, r_host0, r_hostl2, r_hyptrap, r_kern1, r_mon;
  assign r_kern0   = !c.host_l0 && !fld_open(c.kern_fp_en);
  assign r_host0   = c.host_l0 && !fld_open(c.hyp_fp_en);
  assign r_hostl2  = c.host_l2 && fld_low_clear(c.hyp_fp_en);
  assign r_hyptrap = !c.host_l2 && c.hyp_fp_trap;
  assign r_kern1   = fld_low_clear(c.kern_fp_en);
  assign r_mon     = c.top_present && c.mon_fp_trap;

  always_comb begin
    for (int i = 0; i < NSLOT; i++) slot[i] = v_none();
    unique case (lvl)
      LV0: begin
        if (r_kern0)
          slot[0] = c.route ? v_trap(LV2, CLS_ROUTED) : v_trap(LV1, CLS_FPACC);
        if (r_host0)                    slot[1] = v_trap(LV2, CLS_FPACC);
        if (r_hostl2)                   slot[2] = v_trap(LV2, CLS_FPACC);
        if (c.hyp_enabled && r_hyptrap) slot[3] = v_trap(LV2, CLS_FPACC);
        if (r_mon)                      slot[4] = v_mon(c.dbg_undef, CLS_FPACC);
      end
      LV1: begin
        if (r_kern1)                    slot[0] = v_trap(LV1, CLS_FPACC);
        if (c.hyp_enabled && r_hyptrap) slot[1] = v_trap(LV2, CLS_FPACC);
        if (r_hostl2)                   slot[2] = v_trap(LV2, CLS_FPACC);
        if (r_mon)                      slot[3] = v_mon(c.dbg_undef, CLS_FPACC);
      end
      LV2: begin
        if (r_hyptrap)                  slot[0] = v_trap(LV2, CLS_FPACC);
        if (r_hostl2)                   slot[1] = v_trap(LV2, CLS_FPACC);
        if (r_mon)                      slot[2] = v_mon(c.dbg_undef, CLS_FPACC);
      end
      default: begin
        if (c.mon_fp_trap)              slot[0] = v_trap(LV3, CLS_FPACC);
      end
    endcase
  end

  always_comb begin
    v = v_none();
    for (int i = NSLOT - 1; i >= 0; i--)
      if (slot[i].hit) v = slot[i];
  end

  always_comb begin
    // R8
    routed_cls_chk: assert (!(v.hit && !v.undef && v.cls == CLS_ROUTED) ||
                            (lvl == LV0 && v.lvl == LV2))
      else $error("rerouted class outside level 0");
  end

endmodule

// File: rtl/fpmode_access_gate.sv
module fpmode_access_gate
  import fpmode_gate_pkg::*;
(
  input  logic             feat_present,
  input  logic [1:0]       cur_lvl,
  input  logic             top_present,
  input  logic             hyp_enabled,
  input  logic             hyp_host_e2h,
  input  logic             hyp_route_tge,
  input  logic             mon_fpm_en,
  input  logic             mon_hx_en,
  input  logic             mon_fp_trap,
  input  logic             dbg_undef_prio,
  input  logic             dbg_undef,
  input  logic             kern_fpm_en,
  input  logic             hyp_fpm_en,
  input  logic             hx_fpm_en,
  input  logic [1:0]       kern_fp_en,
  input  logic [1:0]       hyp_fp_en,
  input  logic             hyp_fp_trap,
  output logic             acc_allow,
  output logic             acc_undef,
  output logic             acc_trap,
  output logic [1:0]       trap_lvl,
  output logic [5:0]       trap_class
);

  // Derived host and routing states, brought out for the checks.
  logic host_l2, host_l0, route;
  assign host_l2 = hyp_enabled && hyp_host_e2h;
  assign host_l0 = host_l2 && hyp_route_tge;
  assign route   = hyp_enabled && hyp_route_tge;

  logic ev_absent, ev_prio;
  assign ev_absent = !feat_present;
  assign ev_prio   = (cur_lvl != LV3) && top_present && dbg_undef_prio &&
                     (!mon_fpm_en || mon_fp_trap);

  mode_ctrl_t mc;
  acc_ctrl_t  ac;

  assign mc = '{top_present: top_present, hyp_enabled: hyp_enabled,
                host_l0: host_l0, route: route, mon_fpm_en: mon_fpm_en,
                mon_hx_en: mon_hx_en, dbg_undef: dbg_undef,
                kern_fpm_en: kern_fpm_en, hyp_fpm_en: hyp_fpm_en,
                hx_fpm_en: hx_fpm_en};

  assign ac = '{top_present: top_present, hyp_enabled: hyp_enabled,
                host_l0: host_l0, host_l2: host_l2, route: route,
                mon_fp_trap: mon_fp_trap, dbg_undef: dbg_undef,
                kern_fp_en: kern_fp_en, hyp_fp_en: hyp_fp_en,
                hyp_fp_trap: hyp_fp_trap};

  verdict_t v_mode, v_acc, v_fin;

  fpmode_enable_rules u_mode (.lvl(cur_lvl), .c(mc), .v(v_mode));
  fpmode_access_rules u_acc  (.lvl(cur_lvl), .c(ac), .v(v_acc));

  always_comb begin
    if (ev_absent || ev_prio) v_fin = v_undef();
    else if (v_mode.hit)      v_fin = v_mode;
    else if (v_acc.hit)       v_fin = v_acc;
    else                      v_fin = v_none();
  end

  assign acc_allow  = !v_fin.hit;
  assign acc_undef  = v_fin.hit && v_fin.undef;
  assign acc_trap   = v_fin.hit && !v_fin.undef;
  assign trap_lvl   = acc_trap ? v_fin.lvl : LV0;
  assign trap_class = acc_trap ? v_fin.cls : '0;

  always_comb begin
    // R12
    onehot_chk: assert ($onehot({acc_allow, acc_undef, acc_trap}))
      else $error("outcome not one-hot");
    // R12
    idle_zero_chk: assert (acc_trap || (trap_lvl == LV0 && trap_class == '0))
      else $error("trap fields set without a trap");
    // R12
    trap_floor_chk: assert (!acc_trap || (trap_lvl != LV0 && trap_lvl >= cur_lvl))
      else $error("trap to a lower level");
    // R1
    absent_undef_chk: assert (feat_present || acc_undef)
      else $error("absent feature not undefined");
    // R11
    top_no_undef_chk: assert (!(feat_present && cur_lvl == LV3) || !acc_undef)
      else $error("undefined at level 3");
    // R7
    mode_first_chk: assert (!(feat_present && !ev_prio && v_mode.hit && v_acc.hit) ||
                            acc_undef || trap_class == CLS_MODE)
      else $error("access check outranked mode check");
  end

endmodule

// File: tb/fpmode_access_gate_tb.sv
module fpmode_access_gate_tb;

  typedef struct packed {
    logic       feat;
    logic [1:0] lvl;
    logic       top, hyp, e2h, tge;
    logic       mfpm, mhx, mtfp, dprio, dund;
    logic       kfpm, hfpm, hxfpm;
    logic [1:0] kfp, hfp;
    logic       htfp;
  } stim_t;

  typedef struct packed {
    logic       allow, undef, trap;
    logic [1:0] lvl;
    logic [5:0] cls;
  } exp_t;

  localparam int NVEC = 22;
  localparam int NRND = 4000;

  localparam stim_t STIM [NVEC] = '{
    '{1,0,1,1,0,0,1,1,0,0,0,1,1,1,3,3,0},
    '{0,3,1,1,0,0,1,1,0,0,0,1,1,1,3,3,0},
    '{1,0,1,1,0,0,1,1,0,0,0,0,1,1,3,3,0},
    '{1,0,1,1,0,1,1,1,0,0,0,0,1,1,3,3,0},
    '{1,0,1,1,1,1,1,1,0,0,0,1,0,1,3,3,0},
    '{1,1,1,1,0,0,1,0,0,0,0,1,1,1,3,3,0},
    '{1,2,1,1,0,0,0,1,0,0,0,1,1,1,3,3,0},
    '{1,2,1,1,0,0,0,1,0,0,1,1,1,1,3,3,0},
    '{1,1,1,1,0,0,0,1,0,1,0,1,1,1,3,3,0},
    '{1,0,1,1,0,0,1,1,0,0,0,1,1,1,1,3,0},
    '{1,0,1,1,0,1,1,1,0,0,0,1,1,1,1,3,0},
    '{1,1,1,1,0,0,1,1,0,0,0,1,1,1,2,3,0},
    '{1,1,1,1,0,0,1,1,0,0,0,1,1,1,1,3,0},
    '{1,2,1,1,0,0,1,1,0,0,0,1,1,1,3,3,1},
    '{1,3,1,1,0,0,1,1,1,0,1,1,1,1,3,3,0},
    '{1,3,1,1,0,0,0,0,0,1,1,0,0,0,0,0,1},
    '{1,0,1,1,0,0,1,1,0,0,0,0,1,1,0,3,0},
    '{1,2,1,1,1,0,1,1,0,0,0,1,1,1,3,2,0},
    '{1,0,0,1,0,0,0,0,0,0,0,1,1,1,3,3,0},
    '{1,1,1,1,0,0,1,1,1,0,0,1,1,1,3,3,0},
    '{1,0,1,1,1,1,1,1,0,0,0,1,1,1,3,1,0},
    '{1,0,1,1,0,0,1,1,1,1,0,0,1,1,0,3,0}
  };

  localparam exp_t EXPV [NVEC] = '{
    '{1,0,0,0,6'h00},
    '{0,1,0,0,6'h00},
    '{0,0,1,1,6'h18},
    '{0,0,1,2,6'h18},
    '{0,0,1,2,6'h18},
    '{0,0,1,2,6'h18},
    '{0,0,1,3,6'h18},
    '{0,1,0,0,6'h00},
    '{0,1,0,0,6'h00},
    '{0,0,1,1,6'h07},
    '{0,0,1,2,6'h00},
    '{0,0,1,1,6'h07},
    '{1,0,0,0,6'h00},
    '{0,0,1,2,6'h07},
    '{0,0,1,3,6'h07},
    '{1,0,0,0,6'h00},
    '{0,0,1,1,6'h18},
    '{0,0,1,2,6'h07},
    '{1,0,0,0,6'h00},
    '{0,0,1,3,6'h07},
    '{0,0,1,2,6'h07},
    '{0,1,0,0,6'h00}
  };

  localparam string TAGS [NVEC] = '{
    "R12", "R1", "R3", "R3", "R4", "R5", "R6", "R6", "R2", "R8", "R8",
    "R9", "R9", "R10", "R11", "R11", "R7", "R10", "R6", "R11", "R8", "R2"
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  stim_t s = '0;
  logic acc_allow, acc_undef, acc_trap;
  logic [1:0] trap_lvl;
  logic [5:0] trap_class;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  fpmode_access_gate u_dut (
    .feat_present(s.feat), .cur_lvl(s.lvl), .top_present(s.top),
    .hyp_enabled(s.hyp), .hyp_host_e2h(s.e2h), .hyp_route_tge(s.tge),
    .mon_fpm_en(s.mfpm), .mon_hx_en(s.mhx), .mon_fp_trap(s.mtfp),
    .dbg_undef_prio(s.dprio), .dbg_undef(s.dund), .kern_fpm_en(s.kfpm),
    .hyp_fpm_en(s.hfpm), .hx_fpm_en(s.hxfpm), .kern_fp_en(s.kfp),
    .hyp_fp_en(s.hfp), .hyp_fp_trap(s.htfp),
    .acc_allow(acc_allow), .acc_undef(acc_undef), .acc_trap(acc_trap),
    .trap_lvl(trap_lvl), .trap_class(trap_class)
  );

  function automatic exp_t mk_allow();
    return '{1'b1, 1'b0, 1'b0, 2'd0, 6'h00};
  endfunction
  function automatic exp_t mk_undef();
    return '{1'b0, 1'b1, 1'b0, 2'd0, 6'h00};
  endfunction
  function automatic exp_t mk_trap(input logic [1:0] l, input logic [5:0] k);
    return '{1'b0, 1'b0, 1'b1, l, k};
  endfunction

  // Independent reference, written as early-exit rules per requirement.
  function automatic exp_t ref_model(input stim_t t);
    logic h2, h0, rt;
    h2 = t.hyp & t.e2h;
    h0 = h2 & t.tge;
    rt = t.hyp & t.tge;
    if (!t.feat) return mk_undef();                                  // R1
    if (t.lvl == 2'd3) return t.mtfp ? mk_trap(2'd3, 6'h07) : mk_allow(); // R11
    if (t.top && t.dprio && (!t.mfpm || t.mtfp)) return mk_undef();  // R2
    if (t.lvl == 2'd0 && !h0 && !t.kfpm) return mk_trap(rt ? 2'd2 : 2'd1, 6'h18); // R3
    if (t.lvl == 2'd0 && h0 && !t.hfpm) return mk_trap(2'd2, 6'h18); // R4
    if (t.lvl != 2'd2 && t.hyp && !h0 && ((t.top && !t.mhx) || !t.hxfpm))
      return mk_trap(2'd2, 6'h18);                                   // R5
    if (t.top && !t.mfpm) return t.dund ? mk_undef() : mk_trap(2'd3, 6'h18); // R6
    if (t.lvl == 2'd0) begin                                         // R8
      if (!h0 && t.kfp != 2'b11)
        return rt ? mk_trap(2'd2, 6'h00) : mk_trap(2'd1, 6'h07);
      if (h0 && t.hfp != 2'b11) return mk_trap(2'd2, 6'h07);
    end
    if (t.lvl == 2'd1 && !t.kfp[0]) return mk_trap(2'd1, 6'h07);     // R9
    if (h2 && !t.hfp[0]) return mk_trap(2'd2, 6'h07);                // R10
    if (!h2 && t.htfp && (t.hyp || t.lvl == 2'd2)) return mk_trap(2'd2, 6'h07);
    if (t.top && t.mtfp) return t.dund ? mk_undef() : mk_trap(2'd3, 6'h07); // R11
    return mk_allow();
  endfunction

  task automatic check(input exp_t e, input string tag);
    exp_t got;
    got = '{acc_allow, acc_undef, acc_trap, trap_lvl, trap_class};
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s stim=%h got a/u/t=%b%b%b lvl=%0d cls=%h exp a/u/t=%b%b%b lvl=%0d cls=%h",
               tag, s, got.allow, got.undef, got.trap, got.lvl, got.cls,
               e.allow, e.undef, e.trap, e.lvl, e.cls);
    end
  endtask

  task automatic apply(input stim_t t);
    @(posedge clk);
    s = t;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    stim_t base, r;
    // Reset state: every input low, feature absent -> undefined (R1)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(mk_undef(), "R1");
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      apply(STIM[i]);
      check(EXPV[i], TAGS[i]);
    end

    // Biased random sweep: mostly permissive controls, a few flipped (R2..R12)
    base = '{1,0,1,1,0,0,1,1,0,0,0,1,1,1,3,3,0};
    for (int i = 0; i < NRND; i++) begin
      r = base ^ stim_t'($urandom & $urandom & $urandom);
      r.lvl = 2'($urandom);
      r.feat = ($urandom % 16) != 0;
      apply(r);
      check(ref_model(r), "R12");
    end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule